// File: doc/BRIEF.md
# Single-Transfer Descriptor Ring Controller

This block owns the ring of command descriptors that a DMA engine consumes. A requester offers one or two opaque descriptors together with a transfer direction. If no transfer is in flight and no engine reset is running, the block accepts the request and writes the descriptors into consecutive ring slots. It then publishes the new write pointer to the engine. From that point it tracks the single outstanding transfer until the engine reports completion or a dirty error. The engine reports through three write-1-to-clear status bits.

The block also runs the engine reset sequence. It holds the engine reset for a timed interval and then waits a second timed interval after release. It then reloads the engine's pointer and control registers from their initial values and restarts the ring index at slot zero. Any transfer still outstanding at that point is ended with an error. Both waits are given in microseconds and counted in clock cycles of the block's clock.

Top module: `xfer_ring_ctrl`

## Requirements
- R1: After reset the outputs hold their initial values: read pointer 0xEE882266, write pointer 0, end pointer RING_ENTRIES times the entry unit, control enables CTRL_EN, ring base RING_BASE, engine reset low, and no done pulse. The entry unit is 4 when WIDE_ENTRY is 1 and 2 otherwise.
- R2: A request is accepted in the same cycle it is offered (`req_accept` high) when the block is idle. The first descriptor is written at the current ring index in the cycle after acceptance. When `req_two` is 1, the second descriptor is written at the next index in the cycle after that. `req_up`=1 marks an upstream transfer.
- R3: Each descriptor write advances the ring index modulo RING_ENTRIES. At the clock edge that ends the last write, the write pointer becomes the new index times the entry unit.
- R4: While a transfer is in flight or a reset is running, an offered request gets `req_busy` high and `req_accept` low, and no descriptor is written.
- R5: Status bit 2 (dirty) ends an in-flight transfer of either direction with `done` and `done_err` both high, one cycle after it is sampled. It takes priority over the completion bits.
- R6: Status bit 0 (upstream complete) ends only an upstream transfer, and status bit 1 (downstream complete) ends only a downstream transfer. `done` then pulses with `done_err` low. A completion bit for the other direction leaves the transfer in flight.
- R7: One cycle after any status bit is sampled, `sts_clr` pulses with exactly the sampled bits.
- R8: `irq` is high while some status bit is set whose enable bit in `eng_ctrl` is also set.
- R9: A reset request drives `eng_rst` high for CLK_MHZ*WAIT_US cycles and then low for the same number of cycles. The block then restores the write pointer to 0 and the read pointer to 0xEE882266, and the next descriptor goes to ring slot 0.
- R10: At the end of the reset sequence, a transfer still in flight ends with `done` and `done_err` high. Otherwise no `done` pulse is produced.
- R11: A reset request that arrives while a reset sequence is running has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_two | input | 1 | Request carries two descriptors |
| req_up | input | 1 | 1 = upstream, 0 = downstream |
| req_desc0 | input | DESC_W | First descriptor |
| req_desc1 | input | DESC_W | Second descriptor |
| req_accept | output | 1 | Request taken this cycle |
| req_busy | output | 1 | Request refused this cycle |
| dwr_en | output | 1 | Descriptor memory write strobe |
| dwr_idx | output | clog2(RING_ENTRIES) | Ring slot written |
| dwr_data | output | DESC_W | Descriptor written |
| eng_base | output | 32 | Ring base address to engine |
| eng_end | output | 32 | Ring end pointer to engine |
| eng_wptr | output | 32 | Ring write pointer to engine |
| eng_rptr | output | 32 | Ring read pointer to engine |
| eng_ctrl | output | 3 | Status enable bits to engine |
| eng_rst | output | 1 | Engine reset |
| sts_in | input | 3 | Engine status: bit0 up done, bit1 down done, bit2 dirty |
| sts_clr | output | 3 | Write-1-to-clear pulse back to engine |
| irq | output | 1 | Enabled status pending |
| done | output | 1 | Transfer finished pulse |
| done_err | output | 1 | Finished with error (valid with done) |
| rst_req | input | 1 | Request an engine reset sequence |

## Verification
The hardest state to reach from the ports is a reset sequence that starts while a transfer is outstanding and is requested again while still running. The bench leaves an upstream transfer unfinished and raises `rst_req`. A second request is pulsed in the middle of the hold interval. The bench then counts edges to confirm that the release and the error completion land on the exact cycles. Ring wrap-around is reached by running a small ring through mixed one- and two-descriptor requests. The bench tracks its own index, so a two-descriptor write is seen to straddle the last and first slots.

// File: rtl/xfer_ring_pkg.sv
package xfer_ring_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_W0, PH_W1} wr_phase_e;

  localparam logic [31:0] RPTR_INIT = 32'hEE88_2266;

  // slot following idx in a ring of n slots
  function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // engine-visible pointer for a slot index
  function automatic logic [31:0] ring_wptr(int unsigned idx, int unsigned unit);
    return 32'(idx * unit);
  endfunction

endpackage

// File: rtl/xfer_ring_ptr.sv
module xfer_ring_ptr import xfer_ring_pkg::*; #(
  parameter int unsigned RING_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(RING_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_nxt
);
  logic [IDX_W-1:0] idx_q;

  assign idx     = idx_q;
  assign idx_nxt = IDX_W'(ring_next(int'(idx_q), RING_ENTRIES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (clr) idx_q <= '0;
    else if (adv) idx_q <= idx_nxt;
  end

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < RING_ENTRIES);

endmodule

// File: rtl/xfer_sts_eval.sv
module xfer_sts_eval (
  input  logic [2:0] sts,
  input  logic [2:0] enable,
  input  logic       inflight,
  input  logic       upstream,
  output logic       fin,
  output logic       err,
  output logic       irq
);
  logic dirty, up_hit, dn_hit;

  always_comb begin
    dirty  = sts[2];
    up_hit = sts[0] && upstream;
    dn_hit = sts[1] && !upstream;
    fin    = inflight && (dirty || up_hit || dn_hit);
    err    = dirty;
    irq    = |(sts & enable);
  end
endmodule

// File: rtl/xfer_rst_seq.sv
module xfer_rst_seq #(
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned WAIT_US = 100,
  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US,
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic in_reset,
  output logic eng_rst,
  output logic init_ev
);
  typedef enum logic [1:0] {RS_IDLE, RS_HOLD, RS_SETTLE} rs_e;
  rs_e              st;
  logic [CNT_W-1:0] cnt;
  logic             cnt_end;

  assign cnt_end  = (32'(cnt) == WAIT_CYC - 1);
  assign in_reset = (st != RS_IDLE);
  assign init_ev  = (st == RS_SETTLE) && cnt_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RS_IDLE; cnt <= '0; eng_rst <= 1'b0;
    end else begin
      case (st)
        RS_IDLE: if (req) begin
          st <= RS_HOLD; cnt <= '0; eng_rst <= 1'b1;
        end
        RS_HOLD: if (cnt_end) begin
          st <= RS_SETTLE; cnt <= '0; eng_rst <= 1'b0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt_end) begin
          st <= RS_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  p_rst_inside_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> in_reset);
  p_req_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_HOLD && !cnt_end) |=> (st == RS_HOLD && eng_rst));

endmodule

// File: rtl/xfer_ring_ctrl.sv
module xfer_ring_ctrl import xfer_ring_pkg::*; #(
  parameter int unsigned RING_ENTRIES = 16,
  parameter bit          WIDE_ENTRY   = 1'b0,
  parameter int unsigned DESC_W       = 64,
  parameter logic [31:0] RING_BASE    = 32'h0010_0000,
  parameter logic [2:0]  CTRL_EN      = 3'b111,
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned WAIT_US      = 100
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_two,
  input  logic                            req_up,
  input  logic [DESC_W-1:0]               req_desc0,
  input  logic [DESC_W-1:0]               req_desc1,
  output logic                            req_accept,
  output logic                            req_busy,
  output logic                            dwr_en,
  output logic [$clog2(RING_ENTRIES)-1:0] dwr_idx,
  output logic [DESC_W-1:0]               dwr_data,
  output logic [31:0]                     eng_base,
  output logic [31:0]                     eng_end,
  output logic [31:0]                     eng_wptr,
  output logic [31:0]                     eng_rptr,
  output logic [2:0]                      eng_ctrl,
  output logic                            eng_rst,
  input  logic [2:0]                      sts_in,
  output logic [2:0]                      sts_clr,
  output logic                            irq,
  output logic                            done,
  output logic                            done_err,
  input  logic                            rst_req
);
  localparam int unsigned UNIT  = WIDE_ENTRY ? 4 : 2;
  localparam int unsigned IDX_W = $clog2(RING_ENTRIES);
  localparam logic [31:0] END_PTR = 32'(RING_ENTRIES * UNIT);

  wr_phase_e         phase;
  logic              inflight, up_q, two_q;
  logic [DESC_W-1:0] d0_q, d1_q;
  logic [IDX_W-1:0]  idx, idx_nxt;
  logic              in_reset, init_ev, wr_last, fin, fin_err;

  xfer_rst_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US)) u_rst (
    .clk(clk), .rst_n(rst_n), .req(rst_req),
    .in_reset(in_reset), .eng_rst(eng_rst), .init_ev(init_ev));

  xfer_ring_ptr #(.RING_ENTRIES(RING_ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(dwr_en), .clr(init_ev),
    .idx(idx), .idx_nxt(idx_nxt));

  xfer_sts_eval u_eval (
    .sts(sts_in), .enable(eng_ctrl), .inflight(inflight), .upstream(up_q),
    .fin(fin), .err(fin_err), .irq(irq));

  always_comb begin
    req_accept = req_valid && !inflight && !in_reset;
    req_busy   = req_valid && !req_accept;
    dwr_en     = (phase != PH_IDLE);
    dwr_idx    = idx;
    dwr_data   = (phase == PH_W1) ? d1_q : d0_q;
    wr_last    = (phase == PH_W0 && !two_q) || (phase == PH_W1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; inflight <= 1'b0; up_q <= 1'b0; two_q <= 1'b0;
      d0_q <= '0; d1_q <= '0;
      eng_base <= RING_BASE; eng_end <= END_PTR; eng_ctrl <= CTRL_EN;
      eng_wptr <= '0; eng_rptr <= RPTR_INIT;
      sts_clr <= '0; done <= 1'b0; done_err <= 1'b0;
    end else begin
      sts_clr <= sts_in;
      if (init_ev) begin
        phase    <= PH_IDLE;
        inflight <= 1'b0;
        done     <= inflight;
        done_err <= inflight;
        eng_base <= RING_BASE; eng_end <= END_PTR; eng_ctrl <= CTRL_EN;
        eng_wptr <= '0; eng_rptr <= RPTR_INIT;
      end else begin
        done     <= fin;
        done_err <= fin && fin_err;
        if (fin) inflight <= 1'b0;
        if (req_accept) begin
          inflight <= 1'b1; up_q <= req_up; two_q <= req_two;
          d0_q <= req_desc0; d1_q <= req_desc1;
          phase <= PH_W0;
        end else if (wr_last) begin
          phase    <= PH_IDLE;
          eng_wptr <= ring_wptr(int'(idx_nxt), UNIT);
        end else if (phase == PH_W0) begin
          phase <= PH_W1;
        end
      end
    end
  end

  p_no_accept_inflight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight || in_reset) |-> !req_accept);
  p_wptr_moves_on_publish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eng_wptr) |-> $past(wr_last || init_ev));
  p_done_needs_transfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(inflight));
  p_dirty_is_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_in[2] && inflight && !init_ev) |=> (done && done_err));
  p_clr_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_clr == $past(sts_in)));

endmodule

// File: tb/xfer_ring_ctrl_bench.sv
module xfer_ring_ctrl_bench;
  localparam int unsigned N = 4;
  localparam int unsigned UNIT = 2;
  localparam int unsigned W = 8;
  localparam logic [31:0] BASE = 32'h0040_0000;
  localparam logic [2:0]  EN = 3'b011;

  // {up, sts[2:0], exp_done, exp_err}
  localparam logic [5:0] VEC [8] = '{
    6'b1_001_1_0, 6'b1_010_0_0, 6'b0_010_1_0, 6'b0_001_0_0,
    6'b1_100_1_1, 6'b0_110_1_1, 6'b0_011_1_0, 6'b1_101_1_1};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_two = 0, req_up = 0, rst_req = 0;
  logic [63:0] req_desc0 = '0, req_desc1 = '0;
  logic [2:0] sts_in = '0;
  logic req_accept, req_busy, dwr_en, eng_rst, irq, done, done_err;
  logic [1:0] dwr_idx;
  logic [63:0] dwr_data;
  logic [31:0] eng_base, eng_end, eng_wptr, eng_rptr;
  logic [2:0] eng_ctrl, sts_clr;

  int tests = 0, fails = 0, midx = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xfer_ring_ctrl #(.RING_ENTRIES(N), .WIDE_ENTRY(1'b0), .DESC_W(64),
    .RING_BASE(BASE), .CTRL_EN(EN), .CLK_MHZ(1), .WAIT_US(W)) u_xfer_ring_ctrl (
    .clk, .rst_n, .req_valid, .req_two, .req_up, .req_desc0, .req_desc1,
    .req_accept, .req_busy, .dwr_en, .dwr_idx, .dwr_data, .eng_base, .eng_end,
    .eng_wptr, .eng_rptr, .eng_ctrl, .eng_rst, .sts_in, .sts_clr, .irq,
    .done, .done_err, .rst_req);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // R2, R3: issue and follow the descriptor writes
  task automatic issue(bit two, bit up, logic [63:0] a, logic [63:0] b);
    req_valid = 1; req_two = two; req_up = up; req_desc0 = a; req_desc1 = b;
    #1 check("R2 accept", req_accept, 1);
    tick(); req_valid = 0;
    check("R2 write0 en", dwr_en, 1);
    check("R3 write0 idx", dwr_idx, midx);
    check("R2 write0 data", dwr_data, a);
    midx = (midx + 1) % N;
    tick();
    if (two) begin
      check("R3 write1 idx", dwr_idx, midx);
      check("R2 write1 data", dwr_data, b);
      midx = (midx + 1) % N;
      tick();
    end
    check("R2 writes over", dwr_en, 0);
    check("R3 wptr", eng_wptr, midx * UNIT);
  endtask

  task automatic status(logic [2:0] s, bit exp_done, bit exp_err, string tag);
    sts_in = s;
    #1 check("R8 irq", irq, |(s & EN));
    tick(); sts_in = 0;
    check({tag, " done"}, done, exp_done);
    check({tag, " err"}, done_err, exp_err);
    check("R7 clear echo", sts_clr, s);
  endtask

  task automatic refused(string tag);
    req_valid = 1;
    #1 check({tag, " busy"}, req_busy, 1);
    check({tag, " no accept"}, req_accept, 0);
    tick(); req_valid = 0;
    check({tag, " no write"}, dwr_en, 0);
  endtask

  initial begin
    #160000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 rptr", eng_rptr, 32'hEE88_2266);
    check("R1 wptr", eng_wptr, 0);
    check("R1 end", eng_end, N * UNIT);
    check("R1 ctrl", eng_ctrl, EN);
    check("R1 base", eng_base, BASE);
    check("R1 eng_rst", eng_rst, 0);
    check("R1 done", done, 0);

    // R5, R6 vector walk
    foreach (VEC[i]) begin
      issue(0, VEC[i][5], 64'h1000 + i, 64'h0);
      refused("R4 inflight");
      status(VEC[i][4:2], VEC[i][1], VEC[i][0], VEC[i][4] ? "R5" : "R6");
      if (!VEC[i][1]) begin
        refused("R4 still inflight");
        status(3'b100, 1, 1, "R5 dirty finish");
      end
    end
    // R6: status with nothing in flight gives no done
    status(3'b001, 0, 0, "R6 idle");

    // R3 wrap with mixed lengths
    issue(1, 1, 64'hA0, 64'hA1); status(3'b001, 1, 0, "R6 up");
    issue(0, 0, 64'hB0, 64'h0);  status(3'b010, 1, 0, "R6 down");
    issue(1, 1, 64'hC0, 64'hC1); status(3'b001, 1, 0, "R6 up");
    issue(1, 0, 64'hD0, 64'hD1);

    // R9, R10, R11 reset with transfer outstanding
    rst_req = 1; tick(); rst_req = 0;
    check("R9 rst high", eng_rst, 1);
    refused("R4 in reset");
    for (int k = 2; k < W; k++) begin
      if (k == W / 2) rst_req = 1;
      tick(); rst_req = 0;
    end
    check("R11 rst still high", eng_rst, 1);
    tick();
    check("R9 rst released", eng_rst, 0);
    for (int k = 1; k < W; k++) tick();
    check("R10 no early done", done, 0);
    req_valid = 1;
    #1 check("R4 busy in settle", req_busy, 1);
    tick(); req_valid = 0;
    check("R10 done", done, 1);
    check("R10 err", done_err, 1);
    check("R9 wptr", eng_wptr, 0);
    check("R9 rptr", eng_rptr, 32'hEE88_2266);
    midx = 0;
    issue(0, 1, 64'hE0, 64'h0);
    status(3'b001, 1, 0, "R6 after reset");

    // R10: reset with nothing in flight gives no done
    rst_req = 1; tick(); rst_req = 0;
    for (int k = 1; k < 2 * W; k++) tick();
    tick();
    check("R10 idle no done", done, 0);
    check("R9 idle wptr", eng_wptr, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule